// File: doc/BRIEF.md
# Latched Status and Interrupt Register Bank

This block holds the status view of a line framer for a host processor on a small synchronous parallel bus. Level alarms and one-cycle events from the framer set bits in two latched status registers. Those bits stay set until software clears them. A third register shows the synchronizer state live, with no latching. Two mask registers choose which latched bits may pull a shared active-low interrupt line.

Software reads a latched register in three steps. It writes a mask, reads, then writes back the read value ANDed with the mask. The mask write refreshes only the selected bits of a readable copy and acknowledges their interrupts. The write-back clears the selected latched bits. Because of this, one bit can be polled without disturbing the others, and an alarm that arrives between the steps is never lost. Alarm bits interrupt when the alarm turns on and again when it turns off. Event bits interrupt when the event happens.

Register selection: 0 = status A (bits 3..0 alarms, bits 7..4 events), 1 = status B (events), 2 = synchronizer, 3 = enable A, 4 = enable B. All other selects read as zero.

Top module: `stat_irq_bank`

## Requirements
- R1: After reset, all latched bits, readable copies, pending flags and enable registers are zero, and irq_no_o is high.
- R2: An event input held high at a clock edge sets its latched bit. The bit stays set until a write-back clears it, and it does not set again without a new event.
- R3: Alarm bits are bits 3..0 of status A. They set on every edge while the alarm level is high, so a write-back cannot clear them while the alarm persists.
- R4: The first write to a latched register after reset, or after a write-back, is a mask write. Each readable-copy bit with a one in the mask takes the current latched value, and each bit with a zero keeps its old value. A read of the register returns the readable copy.
- R5: The write that follows a mask write to the same register is a write-back. Each one in it clears that latched bit, and the next write is a mask write again.
- R6: When a set and a clearing write-back hit the same bit in the same cycle, the bit stays one.
- R7: Select 2 returns sync_i combinationally. Writes to select 2 have no effect.
- R8: Selects 3 and 4 are readable and writable enable registers. A one enables that bit's interrupt.
- R9: A change of an alarm level in either direction sets its pending flag. An event sets its pending flag.
- R10: A mask write with a one in a bit position clears that bit's pending flag, even while the alarm is still active. Set wins in the same cycle.
- R11: irq_no_o is low exactly when some pending flag has its enable bit set. It changes right after the clock edge that changes either of them.
- R12: rdata_o is zero while rd_i is low and for unused selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| alarm_i | input | 4 | Alarm levels for status A bits 3..0 |
| evt_a_i | input | 4 | Events for status A bits 7..4 |
| evt_b_i | input | 8 | Events for status B |
| sync_i | input | 8 | Live synchronizer state |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Two pairs of functions can land in the same cycle. A framer set can coincide with a clearing write-back, and an alarm edge or event can coincide with the mask write that acknowledges it. The bench provokes both collisions on purpose: it raises events and toggles alarms in the same cycle as write-backs and mask writes. It does this both in directed cases and in a long pseudo-random mix of bus writes and inputs. It then judges the result against a bench model in which set always wins. The model is compared on every register and on the interrupt line after each cycle.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    SEL_LAT_A = 3'd0,
    SEL_LAT_B = 3'd1,
    SEL_SYNC  = 3'd2,
    SEL_MSK_A = 3'd3,
    SEL_MSK_B = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/stat_alarm_edge.sv
module stat_alarm_edge #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_q_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;

  assign chg_o   = lvl_i ^ lvl_q;
  assign lvl_q_o = lvl_q;
endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] pend_set_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] view_o,
  output logic [W-1:0] pend_o
);
  logic         armed;
  logic         snap, clr;
  logic [W-1:0] lat, view, pend, clr_mask, ack_mask;

  // first write snapshots, second write clears
  assign snap     = we_i & ~armed;
  assign clr      = we_i & armed;
  assign clr_mask = clr  ? wdata_i : '0;
  assign ack_mask = snap ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      lat   <= '0;
      view  <= '0;
      pend  <= '0;
    end else begin
      if (snap)     armed <= 1'b1;
      else if (clr) armed <= 1'b0;
      lat  <= set_i | (lat & ~clr_mask);
      if (snap) view <= (wdata_i & lat) | (~wdata_i & view);
      pend <= pend_set_i | (pend & ~ack_mask);
    end
  end

  assign lat_o  = lat;
  assign view_o = view;
  assign pend_o = pend;
endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank
  import stat_bank_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NUM_ALARM = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_ALARM-1:0] alarm_i,
  input  logic [DW-NUM_ALARM-1:0] evt_a_i,
  input  logic [DW-1:0]        evt_b_i,
  input  logic [DW-1:0]        sync_i,
  output logic                 irq_no
);
  localparam int EVA_W = DW - NUM_ALARM;

  logic [NUM_ALARM-1:0] alarm_q, alarm_chg;
  logic [DW-1:0] lat_a, view_a, pend_a, lat_b, view_b, pend_b;
  logic [DW-1:0] msk_a, msk_b;
  logic          we_a, we_b;

  stat_alarm_edge #(.N(NUM_ALARM)) u_alarm_edge (
    .clk_i, .rst_ni, .lvl_i(alarm_i), .lvl_q_o(alarm_q), .chg_o(alarm_chg)
  );

  assign we_a = wr_i && (addr_i == SEL_LAT_A);
  assign we_b = wr_i && (addr_i == SEL_LAT_B);

  stat_latch_reg #(.W(DW)) u_lat_a (
    .clk_i, .rst_ni, .we_i(we_a), .wdata_i,
    .set_i({evt_a_i, alarm_i}), .pend_set_i({evt_a_i, alarm_chg}),
    .lat_o(lat_a), .view_o(view_a), .pend_o(pend_a)
  );

  stat_latch_reg #(.W(DW)) u_lat_b (
    .clk_i, .rst_ni, .we_i(we_b), .wdata_i,
    .set_i(evt_b_i), .pend_set_i(evt_b_i),
    .lat_o(lat_b), .view_o(view_b), .pend_o(pend_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_a <= '0;
      msk_b <= '0;
    end else if (wr_i) begin
      if (addr_i == SEL_MSK_A) msk_a <= wdata_i;
      if (addr_i == SEL_MSK_B) msk_b <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        SEL_LAT_A: rdata_o = view_a;
        SEL_LAT_B: rdata_o = view_b;
        SEL_SYNC:  rdata_o = sync_i;
        SEL_MSK_A: rdata_o = msk_a;
        SEL_MSK_B: rdata_o = msk_b;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign irq_no = ~|((pend_a & msk_a) | (pend_b & msk_b));
endmodule

// File: rtl/stat_irq_bank_chk.sv
module stat_irq_bank_chk #(
  parameter int DW        = 8,
  parameter int NUM_ALARM = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [2:0]           addr_i,
  input logic [DW-1:0]        rdata_o,
  input logic [DW-1:0]        sync_i,
  input logic [NUM_ALARM-1:0] alarm_i,
  input logic [NUM_ALARM-1:0] alarm_q_i,
  input logic [DW-1:0]        evt_b_i,
  input logic [DW-1:0]        lat_a_i,
  input logic [DW-1:0]        lat_b_i,
  input logic [DW-1:0]        pend_a_i,
  input logic                 irq_no
);
  a_r7_sync_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd2) |-> rdata_o == sync_i);

  a_r12_rd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_b_i != '0) |=> ((lat_b_i & $past(evt_b_i)) == $past(evt_b_i)));

  a_r3_alarm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i != '0) |=> ((lat_a_i[NUM_ALARM-1:0] & $past(alarm_i)) == $past(alarm_i)));

  a_r9_alarm_chg_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alarm_i ^ alarm_q_i) != '0) |=>
      ((pend_a_i[NUM_ALARM-1:0] & $past(alarm_i ^ alarm_q_i)) == $past(alarm_i ^ alarm_q_i)));

  a_r11_release_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_no) |-> $past(wr_i));
endmodule

bind stat_irq_bank stat_irq_bank_chk #(.DW(DW), .NUM_ALARM(NUM_ALARM)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .sync_i(sync_i), .alarm_i(alarm_i), .alarm_q_i(alarm_q),
  .evt_b_i(evt_b_i), .lat_a_i(lat_a), .lat_b_i(lat_b), .pend_a_i(pend_a),
  .irq_no(irq_no)
);

// File: tb/stat_irq_bank_tb_top.sv
module stat_irq_bank_tb_top;
  localparam int DW = 8;
  localparam int NA = 4;
  localparam int ST = 3*DW+1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] rdata;
  logic [NA-1:0] alarm = '0;
  logic [DW-NA-1:0] evt_a = '0;
  logic [DW-1:0] evt_b = '0, sync = '0;
  logic          irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state: {armed, pend, view, lat}
  logic [ST-1:0] m_a = '0, m_b = '0;
  logic [DW-1:0] m_ma = '0, m_mb = '0;
  logic [NA-1:0] m_alq = '0;

  always #4 clk = ~clk;

  stat_irq_bank #(.DW(DW), .NUM_ALARM(NA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .alarm_i(alarm), .evt_a_i(evt_a),
    .evt_b_i(evt_b), .sync_i(sync), .irq_no(irq_n)
  );

  function automatic logic [ST-1:0] nxt(input logic [ST-1:0] s, input logic we,
      input logic [DW-1:0] wd, input logic [DW-1:0] set, input logic [DW-1:0] pset);
    logic arm; logic [DW-1:0] lat, view, pend;
    {arm, pend, view, lat} = s;
    if (we && !arm) begin
      view = (wd & lat) | (~wd & view);
      pend = pset | (pend & ~wd);
      lat  = set | lat;
      arm  = 1'b1;
    end else if (we) begin
      lat  = set | (lat & ~wd);
      pend = pset | pend;
      arm  = 1'b0;
    end else begin
      lat  = set | lat;
      pend = pset | pend;
    end
    return {arm, pend, view, lat};
  endfunction

  function automatic logic [DW-1:0] exp_rd(input int a);
    case (a)
      0: return m_a[2*DW-1:DW];
      1: return m_b[2*DW-1:DW];
      2: return sync;
      3: return m_ma;
      4: return m_mb;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ~|((m_a[3*DW-1:2*DW] & m_ma) | (m_b[3*DW-1:2*DW] & m_mb));
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, release strobes
  task automatic cyc(input logic w, input logic [2:0] a, input logic [DW-1:0] d,
      input logic [NA-1:0] al, input logic [DW-NA-1:0] ea, input logic [DW-1:0] eb,
      input logic [DW-1:0] sy);
    wr = w; addr = a; wdata = d; alarm = al; evt_a = ea; evt_b = eb; sync = sy;
    @(posedge clk);
    m_a = nxt(m_a, w && a == 3'd0, d, {ea, al}, {ea, al ^ m_alq});
    m_b = nxt(m_b, w && a == 3'd1, d, eb, eb);
    m_alq = al;
    if (w && a == 3'd3) m_ma = d;
    if (w && a == 3'd4) m_mb = d;
    @(negedge clk);
    wr = 1'b0; evt_a = '0; evt_b = '0;
  endtask

  task automatic probe();
    string tg [5] = '{"R4 status A", "R4 status B", "R7 sync", "R8 enable A", "R8 enable B"};
    for (int a = 0; a < 6; a++) begin
      rd = 1'b1; addr = 3'(a); #1;
      chk(a < 5 ? tg[a] : "R12 unused select", rdata, exp_rd(a));
    end
    rd = 1'b0; #1;
    chk("R12 rd low", rdata, '0);
    chk("R11 irq", {7'd0, irq_n}, {7'd0, exp_irq()});
  endtask

  task automatic rd_one(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
    rd = 1'b1; addr = a; #1;
    chk(tag, rdata, exp);
    rd = 1'b0; #1;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] lstep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    probe();
    chk("R1 irq high", {7'd0, irq_n}, 8'd1);

    // R7 sync live, writes ignored
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 3'd2, ~DW'(v), '0, '0, '0, DW'(v));
      rd_one("R7 sync live", 3'd2, DW'(v));
    end

    // R8 enable registers
    for (int v = 0; v < 256; v++) begin
      cyc(1'b1, 3'd3, DW'(v), '0, '0, '0, '0);
      cyc(1'b1, 3'd4, ~DW'(v), '0, '0, '0, '0);
      probe();
    end
    cyc(1'b1, 3'd3, '0, '0, '0, '0, '0);
    cyc(1'b1, 3'd4, '0, '0, '0, '0, '0);

    // R2/R9/R4/R5 per event bit of status B
    for (int i = 0; i < DW; i++) begin
      cyc(1'b0, 3'd0, '0, '0, '0, DW'(1) << i, '0);
      chk("R8 masked irq stays high", {7'd0, irq_n}, 8'd1);
      cyc(1'b1, 3'd4, 8'hFF, '0, '0, '0, '0);
      chk("R9 event pends irq", {7'd0, irq_n}, 8'd0);
      cyc(1'b1, 3'd1, DW'(1) << i, '0, '0, '0, '0);
      rd_one("R4 snapshot bit", 3'd1, DW'(1) << i);
      chk("R10 ack releases", {7'd0, irq_n}, 8'd1);
      cyc(1'b1, 3'd1, DW'(1) << i, '0, '0, '0, '0);
      cyc(1'b1, 3'd1, 8'hFF, '0, '0, '0, '0);
      rd_one("R5 cleared", 3'd1, 8'h00);
      cyc(1'b1, 3'd1, '0, '0, '0, '0, '0);
      cyc(1'b1, 3'd4, '0, '0, '0, '0, '0);
      probe();
    end

    // R6 set wins over clear
    cyc(1'b0, 3'd0, '0, '0, '0, 8'h01, '0);
    cyc(1'b1, 3'd1, 8'h01, '0, '0, '0, '0);
    cyc(1'b1, 3'd1, 8'h01, '0, '0, 8'h01, '0);
    cyc(1'b1, 3'd1, 8'h01, '0, '0, '0, '0);
    rd_one("R6 set wins", 3'd1, 8'h01);
    cyc(1'b1, 3'd1, 8'h01, '0, '0, '0, '0);
    cyc(1'b1, 3'd1, 8'h01, '0, '0, '0, '0);
    rd_one("R2 no reset without event", 3'd1, 8'h00);
    cyc(1'b1, 3'd1, '0, '0, '0, '0, '0);

    // R3/R9/R10 alarm bit 1 persists, both edges interrupt
    cyc(1'b1, 3'd3, 8'hFF, 4'b0010, '0, '0, '0);
    chk("R9 alarm rise irq", {7'd0, irq_n}, 8'd0);
    cyc(1'b1, 3'd0, 8'h02, 4'b0010, '0, '0, '0);
    chk("R10 ack while alarm active", {7'd0, irq_n}, 8'd1);
    cyc(1'b1, 3'd0, 8'h02, 4'b0010, '0, '0, '0);
    cyc(1'b1, 3'd0, 8'h02, 4'b0010, '0, '0, '0);
    rd_one("R3 alarm persists", 3'd0, 8'h02);
    chk("R11 stays released", {7'd0, irq_n}, 8'd1);
    cyc(1'b0, 3'd0, '0, 4'b0000, '0, '0, '0);
    chk("R9 alarm fall irq", {7'd0, irq_n}, 8'd0);
    cyc(1'b1, 3'd0, '0, 4'b0000, '0, '0, '0);
    probe();

    // mixed pseudo-random traffic, collisions included
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] r1, r2;
      lfsr = lstep(lfsr); r1 = lfsr;
      lfsr = lstep(lfsr); r2 = lfsr;
      cyc(r1[0] | r1[1], (r1[4:2] > 3'd5) ? 3'd0 : r1[4:2], r2[7:0],
          (r1[9:8] == 2'b00) ? r2[11:8] : alarm,
          (r1[11:10] == 2'b00) ? r2[15:12] : '0,
          (r1[13:12] == 2'b00) ? r2[15:8] : '0, r1[15:8]);
      probe();
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule